// File: doc/BRIEF.md
# Ping-Pong Line Buffer Between System and Display Clocks

This block carries decoded picture lines from a fast system clock domain into a slower display clock domain. It uses two line banks that trade roles. While the display side empties one bank, the system side fills the other from an external memory port. A bank changes hands only through a pair of level-coded flags per bank. A write-done flag travels toward the display, and a read-done flag travels back. Each flag passes through a multi-stage synchronizer in the receiving clock. Luma and chroma each have their own pair of banks, so four inferred dual-clock RAMs are in use. All four are addressed together.

The system side accepts start and stop commands and an image base address. It then requests one line at a time at consecutive line addresses and writes the returned pixels into the free bank. When every line of a frame has been shown, it pulses `frame_done`, so that software can supply the address of the next picture. The display side hands out one pixel for each cycle in which the display asks for one and a filled bank is present. In every other cycle it drives black. When display is switched off, the display side returns filled banks without showing them.

Top module: `pingpong_linebuf`

## Requirements
- R1: Displayed pixels (cycles with `disp_valid` high) appear in exactly the order the memory port returned them. Lines pass through bank 0, then bank 1, alternating, for any ratio of the two clocks and any display request pattern.
- R2: A frame consists of LINES_PER_FRAME line requests at addresses base, base+LINE_LEN, base+2·LINE_LEN, and so on. The base of the first frame after enabling is `img_base` when the writer leaves idle. The base of each later frame is `img_base` in the cycle `frame_done` is high.
- R3: `mreq_valid` stays high with a constant `mreq_addr` until `mreq_ack`. Each accepted request is followed by LINE_LEN beats on `rsp_valid`, which fill one bank at addresses 0 to LINE_LEN-1.
- R4: The writer starts a line into a bank only after the read-done for that bank's previous contents has arrived. If the display never asks for pixels, exactly two line requests are issued after start.
- R5: `frame_done` is a one-cycle pulse in the system clock. It occurs only after all pixels of the frame have been shown.
- R6: `start_cmd` enables display and `stop_cmd` disables it; stop wins if both are high together. While display is disabled, no new line request begins. Once the line in flight has been completed, `disp_valid` stays low.
- R7: Whenever `disp_valid` is low, including after reset and when no filled bank is available, `disp_y` equals BLACK_Y (default 0) and `disp_c` equals BLACK_C (default 128).
- R8: Each crossing flag is a level that toggles once for each fill or drain, and at most one flag bit of a direction changes per clock. This lets a two-stage synchronizer carry it safely.
- R9: Banks still filled when display is disabled are discarded by the display side. After a new start, the first shown pixel is pixel 0 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| start_cmd | input | 1 | Enable display (system domain) |
| stop_cmd | input | 1 | Disable display (system domain) |
| img_base | input | ADDR_W | Base address of the picture |
| mreq_valid | output | 1 | Line request to external memory |
| mreq_addr | output | ADDR_W | Address of the requested line |
| mreq_ack | input | 1 | Memory accepted the request |
| rsp_valid | input | 1 | Returned pixel beat valid |
| rsp_y | input | PIX_W | Returned luma sample |
| rsp_c | input | PIX_W | Returned chroma sample |
| frame_done | output | 1 | Pulse: whole frame displayed |
| disp_clk | input | 1 | Display clock |
| disp_rst_n | input | 1 | Active-low reset, display domain |
| disp_req | input | 1 | Display asks for a pixel this cycle |
| disp_valid | output | 1 | Pixel on disp_y/disp_c is real picture data |
| disp_y | output | PIX_W | Luma out, black when not valid |
| disp_c | output | PIX_W | Chroma out, black when not valid |

## Verification
The bench runs several display clock periods, both faster and slower than the system clock, and varies the gaps between memory beats and the display request patterns. A bank swapped early or late would show up as pixels out of order or a line repeated. A display that never requests pixels exposes a writer that overruns a bank before its read-done returns: it would issue a third request. After each stop and restart, the first pixel shown is compared with pixel 0 of the new frame, which catches stale banks that were not discarded. `frame_done` is checked against the number of pixels already shown, which catches a frame count that pulses early.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [2:0] {
      W_IDLE,
      W_WAIT,
      W_REQ,
      W_DATA,
      W_FRAME
   } wr_state_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
   parameter int DW    = 8,
   parameter int DEPTH = 1280,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pp_writer.sv
module pp_writer
   import pp_pkg::*;
#(
   parameter int PIX_W           = 8,
   parameter int LINE_LEN        = 1280,
   parameter int LINES_PER_FRAME = 720,
   parameter int ADDR_W          = 32,
   parameter int PTR_W           = $clog2(LINE_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic [ADDR_W-1:0] img_base,
   output logic              mreq_valid,
   output logic [ADDR_W-1:0] mreq_addr,
   input  logic              mreq_ack,
   input  logic              rsp_valid,
   input  logic [PIX_W-1:0]  rsp_y,
   input  logic [PIX_W-1:0]  rsp_c,
   output logic              frame_done,
   output logic              en_out,
   output logic [1:0]        wr_flag,
   input  logic [1:0]        rd_flag_s,
   output logic              ram_we,
   output logic              ram_bank,
   output logic [PTR_W-1:0]  ram_addr,
   output logic [PIX_W-1:0]  ram_y,
   output logic [PIX_W-1:0]  ram_c
);
   localparam int LN_W  = $clog2(LINES_PER_FRAME);
   localparam int CNT_W = $clog2(LINES_PER_FRAME) + 2;
   localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(LINE_LEN - 1);
   localparam logic [LN_W-1:0]  LAST_LINE = LN_W'(LINES_PER_FRAME - 1);
   localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(LINES_PER_FRAME);

   wr_state_e         state;
   logic              en_q;
   logic              wb;
   logic [PTR_W-1:0]  wptr;
   logic [LN_W-1:0]   line_idx;
   logic [ADDR_W-1:0] line_addr;
   logic [1:0]        seen_q;
   logic [CNT_W-1:0]  shown_cnt;
   logic [CNT_W-1:0]  shown_sum;
   logic              bank_free;
   logic              all_free;

   assign bank_free = (wr_flag[wb] == rd_flag_s[wb]);
   assign all_free  = (wr_flag == rd_flag_s);
   assign shown_sum = shown_cnt + CNT_W'($countones(rd_flag_s ^ seen_q));

   // display enable: stop has priority over start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (stop_cmd)  en_q <= 1'b0;
      else if (start_cmd) en_q <= 1'b1;
   end

   // count lines returned by the display side, pulse at frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= '0;
         shown_cnt  <= '0;
         frame_done <= 1'b0;
      end else begin
         seen_q     <= rd_flag_s;
         frame_done <= 1'b0;
         if (!en_q) begin
            shown_cnt <= '0;
         end else if (shown_sum >= FRAME_CNT) begin
            frame_done <= 1'b1;
            shown_cnt  <= shown_sum - FRAME_CNT;
         end else begin
            shown_cnt <= shown_sum;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= W_IDLE;
         wb        <= 1'b0;
         wptr      <= '0;
         line_idx  <= '0;
         line_addr <= '0;
         wr_flag   <= '0;
      end else begin
         unique case (state)
            W_IDLE: begin
               if (en_q && all_free) begin
                  line_addr <= img_base;
                  line_idx  <= '0;
                  state     <= W_WAIT;
               end
            end
            W_WAIT: begin
               if (!en_q)          state <= W_IDLE;
               else if (bank_free) state <= W_REQ;
            end
            W_REQ: begin
               if (mreq_ack) begin
                  wptr  <= '0;
                  state <= W_DATA;
               end
            end
            W_DATA: begin
               if (rsp_valid) begin
                  wptr <= wptr + PTR_W'(1);
                  if (wptr == LAST_PTR) begin
                     wr_flag[wb] <= ~wr_flag[wb];
                     wb          <= ~wb;
                     line_addr   <= line_addr + ADDR_W'(LINE_LEN);
                     if (line_idx == LAST_LINE) begin
                        line_idx <= '0;
                        state    <= W_FRAME;
                     end else begin
                        line_idx <= line_idx + LN_W'(1);
                        state    <= W_WAIT;
                     end
                  end
               end
            end
            W_FRAME: begin
               if (!en_q) begin
                  state <= W_IDLE;
               end else if (frame_done) begin
                  line_addr <= img_base;
                  state     <= W_WAIT;
               end
            end
            default: state <= W_IDLE;
         endcase
      end
   end

   assign mreq_valid = (state == W_REQ);
   assign mreq_addr  = line_addr;
   assign en_out     = en_q;
   assign ram_we     = (state == W_DATA) && rsp_valid;
   assign ram_bank   = wb;
   assign ram_addr   = wptr;
   assign ram_y      = rsp_y;
   assign ram_c      = rsp_c;
endmodule

// File: rtl/pp_reader.sv
module pp_reader #(
   parameter int LINE_LEN = 1280,
   parameter int PTR_W    = $clog2(LINE_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       wr_flag_s,
   input  logic             en_s,
   input  logic             disp_req,
   output logic [1:0]       rd_flag,
   output logic             ram_re,
   output logic             ram_bank,
   output logic [PTR_W-1:0] ram_addr,
   output logic             out_valid,
   output logic             out_bank
);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(LINE_LEN - 1);

   logic             rb;
   logic [PTR_W-1:0] rptr;
   logic             avail;

   assign avail    = (wr_flag_s[rb] != rd_flag[rb]);
   assign ram_re   = avail && en_s && disp_req;
   assign ram_bank = rb;
   assign ram_addr = rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb        <= 1'b0;
         rptr      <= '0;
         rd_flag   <= '0;
         out_valid <= 1'b0;
         out_bank  <= 1'b0;
      end else begin
         out_valid <= ram_re;
         out_bank  <= rb;
         if (avail && !en_s) begin
            // display off: hand the bank back unseen
            rd_flag[rb] <= ~rd_flag[rb];
            rb          <= ~rb;
            rptr        <= '0;
         end else if (ram_re) begin
            if (rptr == LAST_PTR) begin
               rd_flag[rb] <= ~rd_flag[rb];
               rb          <= ~rb;
               rptr        <= '0;
            end else begin
               rptr <= rptr + PTR_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pingpong_linebuf.sv
module pingpong_linebuf #(
   parameter int               PIX_W           = 8,
   parameter int               LINE_LEN        = 1280,
   parameter int               LINES_PER_FRAME = 720,
   parameter int               ADDR_W          = 32,
   parameter int               SYNC_STAGES     = 2,
   parameter logic [PIX_W-1:0] BLACK_Y         = '0,
   parameter logic [PIX_W-1:0] BLACK_C         = PIX_W'(128)
) (
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic [ADDR_W-1:0] img_base,
   output logic              mreq_valid,
   output logic [ADDR_W-1:0] mreq_addr,
   input  logic              mreq_ack,
   input  logic              rsp_valid,
   input  logic [PIX_W-1:0]  rsp_y,
   input  logic [PIX_W-1:0]  rsp_c,
   output logic              frame_done,
   input  logic              disp_clk,
   input  logic              disp_rst_n,
   input  logic              disp_req,
   output logic              disp_valid,
   output logic [PIX_W-1:0]  disp_y,
   output logic [PIX_W-1:0]  disp_c
);
   localparam int PTR_W  = $clog2(LINE_LEN);
   localparam int NLANES = 2;   // lane 0 luma, lane 1 chroma
   localparam int NBANKS = 2;

   if (LINE_LEN < 2) begin : g_bad_line
      $error("LINE_LEN must be at least 2");
   end
   if (LINES_PER_FRAME < 2) begin : g_bad_frame
      $error("LINES_PER_FRAME must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             en_sys, en_s;
   logic [1:0]       wr_flag, wr_flag_s;
   logic [1:0]       rd_flag, rd_flag_s;
   logic             w_we, w_bank;
   logic [PTR_W-1:0] w_addr;
   logic [PIX_W-1:0] w_y, w_c;
   logic             r_re, r_bank;
   logic [PTR_W-1:0] r_addr;
   logic             r_out_valid, r_out_bank;
   logic [2:0]       s2d_q;

   logic [PIX_W-1:0] lane_wdata [NLANES];
   logic [PIX_W-1:0] lane_rdata [NLANES][NBANKS];

   pp_writer #(
      .PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .LINES_PER_FRAME(LINES_PER_FRAME),
      .ADDR_W(ADDR_W), .PTR_W(PTR_W)
   ) u_writer (
      .clk(sys_clk), .rst_n(sys_rst_n),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .img_base(img_base),
      .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_ack(mreq_ack),
      .rsp_valid(rsp_valid), .rsp_y(rsp_y), .rsp_c(rsp_c),
      .frame_done(frame_done), .en_out(en_sys),
      .wr_flag(wr_flag), .rd_flag_s(rd_flag_s),
      .ram_we(w_we), .ram_bank(w_bank), .ram_addr(w_addr),
      .ram_y(w_y), .ram_c(w_c)
   );

   pp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_s2d (
      .clk(disp_clk), .rst_n(disp_rst_n),
      .d({en_sys, wr_flag}), .q(s2d_q)
   );
   assign en_s      = s2d_q[2];
   assign wr_flag_s = s2d_q[1:0];

   pp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_d2s (
      .clk(sys_clk), .rst_n(sys_rst_n),
      .d(rd_flag), .q(rd_flag_s)
   );

   pp_reader #(.LINE_LEN(LINE_LEN), .PTR_W(PTR_W)) u_reader (
      .clk(disp_clk), .rst_n(disp_rst_n),
      .wr_flag_s(wr_flag_s), .en_s(en_s), .disp_req(disp_req),
      .rd_flag(rd_flag), .ram_re(r_re), .ram_bank(r_bank), .ram_addr(r_addr),
      .out_valid(r_out_valid), .out_bank(r_out_bank)
   );

   assign lane_wdata[0] = w_y;
   assign lane_wdata[1] = w_c;

   for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
      for (genvar bk = 0; bk < NBANKS; bk++) begin : g_bank
         pp_dpram #(.DW(PIX_W), .DEPTH(LINE_LEN), .AW(PTR_W)) u_ram (
            .wclk(sys_clk),
            .we(w_we && (w_bank == 1'(bk))),
            .waddr(w_addr),
            .wdata(lane_wdata[ln]),
            .rclk(disp_clk),
            .re(r_re && (r_bank == 1'(bk))),
            .raddr(r_addr),
            .rdata(lane_rdata[ln][bk])
         );
      end
   end

   assign disp_valid = r_out_valid;
   assign disp_y     = r_out_valid ? lane_rdata[0][r_out_bank] : BLACK_Y;
   assign disp_c     = r_out_valid ? lane_rdata[1][r_out_bank] : BLACK_C;
endmodule

// File: rtl/pingpong_linebuf_chk.sv
module pingpong_linebuf_chk #(
   parameter int ADDR_W = 32
) (
   input logic              sys_clk,
   input logic              sys_rst_n,
   input logic              disp_clk,
   input logic              disp_rst_n,
   input logic              mreq_valid,
   input logic              mreq_ack,
   input logic [ADDR_W-1:0] mreq_addr,
   input logic              frame_done,
   input logic              en_sys,
   input logic              w_we,
   input logic              w_bank,
   input logic [1:0]        wr_flag,
   input logic [1:0]        rd_flag_s,
   input logic [1:0]        rd_flag
);
   // R3
   mreq_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (mreq_valid && !mreq_ack) |=> (mreq_valid && $stable(mreq_addr)));

   // R5
   frame_pulse_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      frame_done |=> !frame_done);

   // R4
   bank_free_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      w_we |-> (wr_flag[w_bank] == rd_flag_s[w_bank]));

   // R6
   req_enabled_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $rose(mreq_valid) |-> $past(en_sys));

   // R8
   wr_step_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $countones(wr_flag ^ $past(wr_flag)) <= 1);

   // R8
   rd_step_chk: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
      $countones(rd_flag ^ $past(rd_flag)) <= 1);
endmodule

bind pingpong_linebuf pingpong_linebuf_chk #(.ADDR_W(ADDR_W)) i_chk (
   .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
   .disp_clk(disp_clk), .disp_rst_n(disp_rst_n),
   .mreq_valid(mreq_valid), .mreq_ack(mreq_ack), .mreq_addr(mreq_addr),
   .frame_done(frame_done), .en_sys(en_sys),
   .w_we(w_we), .w_bank(w_bank),
   .wr_flag(wr_flag), .rd_flag_s(rd_flag_s), .rd_flag(rd_flag)
);

// File: tb/test_pingpong_linebuf.sv
module test_pingpong_linebuf;
   localparam int LINE     = 8;
   localparam int LINES    = 3;
   localparam int FRAME_PX = LINE * LINES;
   localparam int AW       = 16;
   localparam logic [7:0] BLK_Y = 8'd0;
   localparam logic [7:0] BLK_C = 8'd128;

   typedef struct packed {
      logic [15:0] b1;
      logic [15:0] b2;
      int          half;
      int          mode;
      int          gap;
   } scen_t;

   localparam int NSC = 4;
   localparam scen_t SCEN [NSC] = '{
      '{16'h0100, 16'h0400,  7, 0, 0},
      '{16'h1230, 16'h2000, 29, 1, 1},
      '{16'h0FF8, 16'h7770, 13, 2, 2},
      '{16'hABC0, 16'h0040, 17, 0, 0}
   };

   logic          sys_clk = 1'b0, disp_clk = 1'b0;
   logic          sys_rst_n = 1'b0, disp_rst_n = 1'b0;
   logic          start_cmd = 1'b0, stop_cmd = 1'b0;
   logic [AW-1:0] img_base = '0;
   logic          mreq_valid, mreq_ack;
   logic [AW-1:0] mreq_addr;
   logic          rsp_valid;
   logic [7:0]    rsp_y, rsp_c;
   logic          frame_done;
   logic          disp_req = 1'b0;
   logic          disp_valid;
   logic [7:0]    disp_y, disp_c;

   int disp_half = 7;
   int req_mode = 0;
   int gap = 0;
   logic [15:0] cur_b1, cur_b2;

   int nchk = 0, nerr = 0;
   int seen_px, bad_px, black_bad, req_cnt, addr_bad, fd_cnt, fd_early;
   logic [15:0] first_addr;
   logic [7:0]  first_y, bad_act, bad_exp;
   bit          finished = 1'b0;

   always #10 sys_clk = ~sys_clk;
   always #(disp_half) disp_clk = ~disp_clk;

   pingpong_linebuf #(
      .PIX_W(8), .LINE_LEN(LINE), .LINES_PER_FRAME(LINES), .ADDR_W(AW)
   ) i_pingpong_linebuf (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .img_base(img_base),
      .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_ack(mreq_ack),
      .rsp_valid(rsp_valid), .rsp_y(rsp_y), .rsp_c(rsp_c),
      .frame_done(frame_done),
      .disp_clk(disp_clk), .disp_rst_n(disp_rst_n), .disp_req(disp_req),
      .disp_valid(disp_valid), .disp_y(disp_y), .disp_c(disp_c)
   );

   function automatic logic [7:0] fy(logic [15:0] a);
      logic [15:0] m;
      m = a * 16'd5 + 16'd3;
      return m[7:0] ^ a[15:8];
   endfunction

   function automatic logic [7:0] fc(logic [15:0] a);
      return a[7:0] ^ 8'h96;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_counts();
      seen_px = 0; bad_px = 0; black_bad = 0; req_cnt = 0;
      addr_bad = 0; fd_cnt = 0; fd_early = 0; first_addr = '0; first_y = '0;
   endtask

   // external memory model: ack, then one line of beats
   initial begin
      logic [15:0] a, exp_a;
      mreq_ack = 1'b0; rsp_valid = 1'b0; rsp_y = '0; rsp_c = '0;
      forever begin
         @(negedge sys_clk);
         if (mreq_valid) begin
            a = mreq_addr;
            exp_a = ((req_cnt / LINES) == 0 ? cur_b1 : cur_b2)
                    + 16'((req_cnt % LINES) * LINE);
            if (req_cnt == 0) first_addr = a;
            if (a != exp_a) addr_bad++;
            req_cnt++;
            mreq_ack = 1'b1;
            @(negedge sys_clk);
            mreq_ack = 1'b0;
            for (int k = 0; k < LINE; k++) begin
               repeat (gap) @(negedge sys_clk);
               rsp_valid = 1'b1;
               rsp_y = fy(a + 16'(k));
               rsp_c = fc(a + 16'(k));
               @(negedge sys_clk);
               rsp_valid = 1'b0;
            end
         end
      end
   end

   // display request pattern
   initial begin
      int cyc = 0;
      forever begin
         @(negedge disp_clk);
         cyc++;
         case (req_mode)
            0: disp_req = 1'b1;
            1: disp_req = (cyc % 2) == 0;
            2: disp_req = (cyc % 3) == 0;
            default: disp_req = 1'b0;
         endcase
      end
   end

   // display collector
   initial begin
      logic [15:0] a;
      forever begin
         @(negedge disp_clk);
         if (disp_valid) begin
            a = ((seen_px / FRAME_PX) == 0 ? cur_b1 : cur_b2)
                + 16'(seen_px % FRAME_PX);
            if (seen_px == 0) first_y = disp_y;
            if (disp_y != fy(a) || disp_c != fc(a)) begin
               if (bad_px == 0) begin bad_act = disp_y; bad_exp = fy(a); end
               bad_px++;
            end
            seen_px++;
         end else if (disp_y != BLK_Y || disp_c != BLK_C) begin
            black_bad++;
         end
      end
   end

   // frame-done monitor
   initial begin
      forever begin
         @(negedge sys_clk);
         if (frame_done) begin
            fd_cnt++;
            if (seen_px < fd_cnt * FRAME_PX) fd_early++;
         end
      end
   end

   task automatic start_and_retarget(input logic [15:0] b1, input logic [15:0] b2);
      cur_b1 = b1; cur_b2 = b2; img_base = b1;
      @(negedge sys_clk); start_cmd = 1'b1;
      @(negedge sys_clk); start_cmd = 1'b0;
      for (int t = 0; t < 2000 && req_cnt == 0; t++) @(negedge sys_clk);
      img_base = b2;
   endtask

   task automatic stop_and_check_quiet(input int idx);
      int rq, dv;
      @(negedge sys_clk); stop_cmd = 1'b1;
      @(negedge sys_clk); stop_cmd = 1'b0;
      repeat (150) @(negedge sys_clk);
      rq = 0; dv = 0;
      for (int t = 0; t < 200; t++) begin
         @(negedge sys_clk);
         if (mreq_valid) rq++;
         if (disp_valid) dv++;
      end
      check(rq == 0, "R6", $sformatf("scenario %0d requests while disabled", idx), rq, 0);
      check(dv == 0, "R6", $sformatf("scenario %0d valid pixels while disabled", idx), dv, 0);
   endtask

   task automatic run_scenario(input int idx);
      disp_half = SCEN[idx].half;
      req_mode  = SCEN[idx].mode;
      gap       = SCEN[idx].gap;
      repeat (20) @(negedge sys_clk);
      clear_counts();
      start_and_retarget(SCEN[idx].b1, SCEN[idx].b2);
      for (int t = 0; t < 20000 && seen_px < 2 * FRAME_PX; t++) @(negedge sys_clk);
      repeat (60) @(negedge sys_clk);
      check(first_addr == SCEN[idx].b1, "R2", $sformatf("scenario %0d first line address", idx),
            first_addr, SCEN[idx].b1);
      check(addr_bad == 0, "R2", $sformatf("scenario %0d line address sequence errors", idx),
            addr_bad, 0);
      check(seen_px >= 2 * FRAME_PX, "R1", $sformatf("scenario %0d pixels shown", idx),
            seen_px, 2 * FRAME_PX);
      check(bad_px == 0, "R1", $sformatf("scenario %0d pixel order (first bad %0d vs %0d)",
            idx, bad_act, bad_exp), bad_px, 0);
      check(black_bad == 0, "R7", $sformatf("scenario %0d non-black idle output", idx),
            black_bad, 0);
      check(fd_cnt >= 2, "R5", $sformatf("scenario %0d frame_done pulses", idx), fd_cnt, 2);
      check(fd_early == 0, "R5", $sformatf("scenario %0d early frame_done", idx), fd_early, 0);
      if (idx > 0)
         check(first_y == fy(SCEN[idx].b1), "R9",
               $sformatf("scenario %0d first pixel after restart", idx), first_y, fy(SCEN[idx].b1));
      stop_and_check_quiet(idx);
   endtask

   initial begin
      repeat (6) @(negedge sys_clk);
      sys_rst_n = 1'b1; disp_rst_n = 1'b1;
      repeat (4) @(negedge sys_clk);
      // reset state
      check(mreq_valid == 1'b0, "R6", "request after reset", mreq_valid, 0);
      check(frame_done == 1'b0, "R5", "frame_done after reset", frame_done, 0);
      @(negedge disp_clk);
      check(disp_valid == 1'b0, "R7", "valid after reset", disp_valid, 0);
      check(disp_y == BLK_Y && disp_c == BLK_C, "R7", "black luma after reset", disp_y, BLK_Y);

      for (int i = 0; i < NSC; i++) run_scenario(i);

      // R4: display never asks, so only the two banks get filled
      disp_half = 11; req_mode = 3; gap = 0;
      repeat (20) @(negedge sys_clk);
      clear_counts();
      start_and_retarget(16'h3000, 16'h5000);
      repeat (300) @(negedge sys_clk);
      check(req_cnt == 2, "R4", "requests with display stalled", req_cnt, 2);
      check(seen_px == 0, "R4", "pixels shown with display stalled", seen_px, 0);
      check(black_bad == 0, "R7", "black while stalled", black_bad, 0);
      req_mode = 0;
      for (int t = 0; t < 20000 && seen_px < FRAME_PX; t++) @(negedge sys_clk);
      repeat (20) @(negedge sys_clk);
      check(seen_px >= FRAME_PX && bad_px == 0, "R1", "order after stall released",
            bad_px, 0);
      stop_and_check_quiet(NSC);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge sys_clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++; nerr++;
         $display("FAIL R1 watchdog expired: actual 0 expected 1");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule